// File: doc/BRIEF.md
# IO page table walker

This block turns one device virtual address into a system physical address after a translation cache miss. A request carries the source's requester ID, the virtual address and a read/write flag. The walker first fetches the device's context entry from a table whose base comes from a configuration input. The entry is indexed by requester ID, and each entry is 32 bytes. The context entry gives the starting level, the root table and the first pair of access rights.

The walker then descends through 4 KB translation tables, one 64-bit memory read per level. Each table entry names the level of the table it points to. This lets the walk skip levels whose virtual address bits are zero, and it lets the walk end early on a large page. The walker handles one request at a time. Its response is either a physical address together with the level of the page that mapped it, or an abort with a fault code that an event logger can record. The response also carries the device's domain number.

Top module: `io_page_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is low from the next cycle until the response has been given.
- R2: The context entry is fetched with two reads, first at `cfg_dt_base + rid*32` and then 8 bytes higher. In the first word, bit 0 is valid, bits 11:9 are the start level, bits 51:12 are the root table frame, bit 61 is read-allowed and bit 62 is write-allowed. Bits 15:0 of the second word are the domain.
- R3: A context entry whose valid bit is clear aborts the walk with fault code 1, after exactly the two context reads.
- R4: A start level of 0, or a start level above the deepest level the address width needs (4 for 48 bits), gives fault code 5. If any virtual address bit at or above position 12+9*start is set, the result is fault code 4.
- R5: The entry at level L is read at `{table[51:12], va[12+9*(L-1)+8 : 12+9*(L-1)], 3'b000}`. Bit 0 of an entry is present, bits 11:9 are the next level (0 marks a leaf), bits 51:12 are a frame number, bit 61 is read and bit 62 is write.
- R6: An entry whose present bit is clear gives fault code 2.
- R7: The read and write rights are each ANDed over the context entry and every entry walked. A write request is judged by the write result and a read request by the read result. A denial gives fault code 3 at the first level where it appears.
- R8: A non-leaf next level that is not below the current level gives fault code 5. When the next level N is below L-1, the virtual address bits [12+9*N, 12+9*(L-1)) must all be zero, otherwise the result is fault code 4.
- R9: A leaf at level n maps a page of 2^(12+9*(n-1)) bytes. The response takes the entry's address bits above that size and the virtual address bits below it, and `rsp_lvl` is n. Frame bits below the page size are ignored.
- R10: An error on any memory read gives fault code 6 and ends the walk with no further reads.
- R11: `rsp_valid` is high for exactly one cycle, in the cycle after the final read was acknowledged. A fault response has `rsp_pa` and `rsp_lvl` at zero, and a success has fault code 0.
- R12: Within one entry the checks are made in this order: present, rights, level order, skipped bits. Within the context entry the order is: valid, start level, upper address bits, rights.
- R13: `rsp_domain` carries the domain from the second context word for every response that follows a good read of both context words, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dt_base | input | 52 | Byte address of the device context table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_rid | input | RID_W | Requester ID |
| req_va | input | VA_W | Device virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 52 | Byte address of the 64-bit word to read |
| mem_ack | input | 1 | Read data or error is returned this cycle |
| mem_rdata | input | 64 | Read data |
| mem_err | input | 1 | The read failed |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 3 | 0 for success, otherwise a fault code |
| rsp_pa | output | 52 | Translated physical address |
| rsp_lvl | output | 3 | Level of the leaf that mapped the page |
| rsp_domain | output | 16 | Domain of the requesting device |

## Verification
A walk makes two context reads and then one read per level it visits. Its response is due in the cycle after the last of those reads is acknowledged, so the latency depends on the table shape and on the memory's random wait states. The bench's memory model logs the address and the clock count of every acknowledge. It then checks the number of reads, each address against the reference walk, and that the response pulse lands one clock after the last acknowledge and drops on the next clock. All sampling happens on falling edges, half a period away from the edge where the walker acts.

// File: rtl/iowalk_pkg.sv
package iowalk_pkg;

  localparam int PA_W  = 52;
  localparam int ENT_W = 64;
  localparam int LVL_W = 3;
  localparam int IDX_W = 9;
  localparam int PG_SH = 12;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_DEV_INVALID = 3'd1,
    FLT_NOT_PRESENT = 3'd2,
    FLT_PERM        = 3'd3,
    FLT_ADDR_BITS   = 3'd4,
    FLT_BAD_LEVEL   = 3'd5,
    FLT_HW_ERR      = 3'd6
  } fault_e;

  typedef struct packed {
    logic [39:0] frame;
    logic        wr;
    logic        rd;
    logic [2:0]  nxt;
    logic        vld;
  } ent_t;

  function automatic ent_t ent_decode(input logic [63:0] e);
    ent_t r;
    r.frame = e[51:12];
    r.wr    = e[62];
    r.rd    = e[61];
    r.nxt   = e[11:9];
    r.vld   = e[0];
    return r;
  endfunction

  // lowest virtual address bit indexed by a table at level lvl
  function automatic int unsigned lvl_shift(input logic [2:0] lvl);
    if (lvl == 3'd0) return 32'd12;
    return 32'd12 + 32'd9 * (32'(lvl) - 32'd1);
  endfunction

  function automatic logic [8:0] lvl_index(input logic [63:0] va, input logic [2:0] lvl);
    logic [63:0] s;
    s = va >> lvl_shift(lvl);
    return s[8:0];
  endfunction

  // 1 when va bits lo .. hi-1 are all zero
  function automatic logic zero_span(input logic [63:0] va, input int unsigned lo,
                                     input int unsigned hi);
    logic r;
    r = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i >= lo && i < hi && va[i]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [51:0] leaf_addr(input logic [39:0] frame, input logic [63:0] va,
                                            input logic [2:0] lvl);
    logic [63:0] m;
    logic [63:0] b;
    logic [63:0] t;
    m = (64'd1 << lvl_shift(lvl)) - 64'd1;
    b = {12'd0, frame, 12'd0};
    t = (b & ~m) | (va & m);
    return t[51:0];
  endfunction

  function automatic logic denied(input logic rd, input logic wr, input logic is_write);
    return is_write ? !wr : !rd;
  endfunction

endpackage

// File: rtl/iowalk_dte_chk.sv
module iowalk_dte_chk
  import iowalk_pkg::*;
#(
  parameter int MAX_LVL = 4
) (
  input  logic [63:0] dte_lo,
  input  logic [63:0] va,
  input  logic        is_write,
  output fault_e      flt,
  output logic [2:0]  start_lvl,
  output logic [51:0] root,
  output logic        perm_r,
  output logic        perm_w
);

  ent_t f;
  logic lvl_bad;
  logic hi_clear;

  assign f         = ent_decode(dte_lo);
  assign start_lvl = f.nxt;
  assign root      = {f.frame, 12'd0};
  assign perm_r    = f.rd;
  assign perm_w    = f.wr;
  assign lvl_bad   = (f.nxt == 3'd0) || (int'(f.nxt) > MAX_LVL);
  assign hi_clear  = zero_span(va, lvl_shift(f.nxt) + 32'd9, 32'd64);

  always_comb begin
    flt = FLT_NONE;
    if (!f.vld)                         flt = FLT_DEV_INVALID;
    else if (lvl_bad)                   flt = FLT_BAD_LEVEL;
    else if (!hi_clear)                 flt = FLT_ADDR_BITS;
    else if (denied(f.rd, f.wr, is_write)) flt = FLT_PERM;
  end

endmodule

// File: rtl/iowalk_pte_eval.sv
module iowalk_pte_eval
  import iowalk_pkg::*;
(
  input  logic [63:0] ent,
  input  logic [63:0] va,
  input  logic [2:0]  cur_lvl,
  input  logic        acc_r,
  input  logic        acc_w,
  input  logic        is_write,
  output fault_e      flt,
  output logic        leaf,
  output logic        skip,
  output logic [2:0]  nxt_lvl,
  output logic [51:0] nxt_base,
  output logic        new_r,
  output logic        new_w,
  output logic [51:0] pa
);

  ent_t f;
  logic order_bad;
  logic gap_clear;

  assign f        = ent_decode(ent);
  assign leaf     = (f.nxt == 3'd0);
  assign nxt_lvl  = f.nxt;
  assign nxt_base = {f.frame, 12'd0};
  assign new_r    = acc_r & f.rd;
  assign new_w    = acc_w & f.wr;
  assign pa       = leaf_addr(f.frame, va, cur_lvl);
  assign order_bad = !leaf && (f.nxt >= cur_lvl);
  assign skip     = !leaf && (int'(f.nxt) + 1 < int'(cur_lvl));
  assign gap_clear = zero_span(va, lvl_shift(f.nxt) + 32'd9, lvl_shift(cur_lvl));

  always_comb begin
    flt = FLT_NONE;
    if (!f.vld)                            flt = FLT_NOT_PRESENT;
    else if (denied(new_r, new_w, is_write)) flt = FLT_PERM;
    else if (order_bad)                    flt = FLT_BAD_LEVEL;
    else if (skip && !gap_clear)           flt = FLT_ADDR_BITS;
  end

endmodule

// File: rtl/io_page_walker.sv
module io_page_walker
  import iowalk_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int RID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [51:0]      cfg_dt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [RID_W-1:0] req_rid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  output logic             mem_req,
  output logic [51:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [63:0]      mem_rdata,
  input  logic             mem_err,
  output logic             rsp_valid,
  output logic [2:0]       rsp_fault,
  output logic [51:0]      rsp_pa,
  output logic [2:0]       rsp_lvl,
  output logic [15:0]      rsp_domain
);

  localparam int MAX_LVL = (VA_W - PG_SH + IDX_W - 1) / IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_DTE0, S_DTE1, S_PTE, S_RESP} st_e;

  st_e         state;
  logic [63:0] va_q;
  logic        wr_q;
  logic [51:0] dte_addr_q;
  logic [63:0] dte_lo_q;
  logic [2:0]  cur_lvl;
  logic [51:0] tbl_q;
  logic        acc_r, acc_w;
  logic [2:0]  fault_q;
  logic [51:0] pa_q;
  logic [2:0]  lvl_q;
  logic [15:0] dom_q;

  // named events
  logic   walk_accept;
  logic   rd_done;
  logic   rd_fail;
  logic   walk_step;

  fault_e dte_flt;
  logic [2:0]  dte_lvl;
  logic [51:0] dte_root;
  logic        dte_r, dte_w;

  fault_e pte_flt;
  logic        pte_leaf, pte_skip, pte_r, pte_w;
  logic [2:0]  pte_nxt;
  logic [51:0] pte_base, pte_pa;

  iowalk_dte_chk #(.MAX_LVL(MAX_LVL)) u_dte (
    .dte_lo   (dte_lo_q),
    .va       (va_q),
    .is_write (wr_q),
    .flt      (dte_flt),
    .start_lvl(dte_lvl),
    .root     (dte_root),
    .perm_r   (dte_r),
    .perm_w   (dte_w)
  );

  iowalk_pte_eval u_pte (
    .ent      (mem_rdata),
    .va       (va_q),
    .cur_lvl  (cur_lvl),
    .acc_r    (acc_r),
    .acc_w    (acc_w),
    .is_write (wr_q),
    .flt      (pte_flt),
    .leaf     (pte_leaf),
    .skip     (pte_skip),
    .nxt_lvl  (pte_nxt),
    .nxt_base (pte_base),
    .new_r    (pte_r),
    .new_w    (pte_w),
    .pa       (pte_pa)
  );

  assign req_ready   = (state == S_IDLE);
  assign walk_accept = req_valid && req_ready;
  assign mem_req     = (state == S_DTE0) || (state == S_DTE1) || (state == S_PTE);
  assign rd_done     = mem_req && mem_ack;
  assign rd_fail     = rd_done && mem_err;
  assign walk_step   = (state == S_PTE) && rd_done && !mem_err &&
                       (pte_flt == FLT_NONE) && !pte_leaf;

  assign rsp_valid  = (state == S_RESP);
  assign rsp_fault  = fault_q;
  assign rsp_pa     = pa_q;
  assign rsp_lvl    = lvl_q;
  assign rsp_domain = dom_q;

  always_comb begin
    case (state)
      S_DTE0:  mem_addr = dte_addr_q;
      S_DTE1:  mem_addr = dte_addr_q + 52'd8;
      S_PTE:   mem_addr = {tbl_q[51:12], lvl_index(va_q, cur_lvl), 3'b000};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      dte_addr_q <= '0;
      dte_lo_q   <= '0;
      cur_lvl    <= '0;
      tbl_q      <= '0;
      acc_r      <= 1'b0;
      acc_w      <= 1'b0;
      fault_q    <= '0;
      pa_q       <= '0;
      lvl_q      <= '0;
      dom_q      <= '0;
    end else begin
      case (state)
        S_IDLE: if (walk_accept) begin
          va_q       <= 64'(req_va);
          wr_q       <= req_write;
          dte_addr_q <= cfg_dt_base + (52'(req_rid) << 5);
          dom_q      <= '0;
          fault_q    <= '0;
          pa_q       <= '0;
          lvl_q      <= '0;
          state      <= S_DTE0;
        end
        S_DTE0: if (rd_done) begin
          if (mem_err) begin
            fault_q <= FLT_HW_ERR;
            state   <= S_RESP;
          end else begin
            dte_lo_q <= mem_rdata;
            state    <= S_DTE1;
          end
        end
        S_DTE1: if (rd_done) begin
          if (mem_err) begin
            fault_q <= FLT_HW_ERR;
            state   <= S_RESP;
          end else begin
            dom_q <= mem_rdata[15:0];
            if (dte_flt != FLT_NONE) begin
              fault_q <= dte_flt;
              state   <= S_RESP;
            end else begin
              cur_lvl <= dte_lvl;
              tbl_q   <= dte_root;
              acc_r   <= dte_r;
              acc_w   <= dte_w;
              state   <= S_PTE;
            end
          end
        end
        S_PTE: if (rd_done) begin
          if (mem_err) begin
            fault_q <= FLT_HW_ERR;
            state   <= S_RESP;
          end else if (pte_flt != FLT_NONE) begin
            fault_q <= pte_flt;
            state   <= S_RESP;
          end else if (pte_leaf) begin
            pa_q  <= pte_pa;
            lvl_q <= cur_lvl;
            state <= S_RESP;
          end else begin
            cur_lvl <= pte_nxt;
            tbl_q   <= pte_base;
            acc_r   <= pte_r;
            acc_w   <= pte_w;
          end
        end
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);  // R1

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));  // R2

  AST_LEVEL_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_step |=> (cur_lvl < $past(cur_lvl)) && (cur_lvl != 3'd0));  // R8

  AST_SKIP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_step && pte_skip |=> (cur_lvl + 3'd1) < $past(cur_lvl));  // R8

  AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_lvl != 3'd0 && int'(rsp_lvl) <= MAX_LVL);  // R9

  AST_ERR_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail |=> rsp_valid && rsp_fault == 3'd6 && !mem_req);  // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);  // R11

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_pa == 52'd0 && rsp_lvl == 3'd0);  // R11

endmodule

// File: tb/io_page_walker_test.sv
module io_page_walker_test;

  localparam int VA_W = 48;
  localparam logic [51:0] DT_BASE = 52'h000_0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_rid = '0;
  logic [VA_W-1:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req;
  logic [51:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [51:0] rsp_pa;
  logic [2:0]  rsp_lvl;
  logic [15:0] rsp_domain;

  always #10 clk = ~clk;  // 50 MHz

  io_page_walker #(.VA_W(VA_W), .RID_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_dt_base(DT_BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid),
    .req_va(req_va), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_lvl(rsp_lvl), .rsp_domain(rsp_domain)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] mem_m [logic [51:0]];
  logic [51:0] wlist [0:15];
  int          wn;
  bit          err_en = 0;
  logic [51:0] err_addr = '0;
  logic [51:0] act_addr [0:15];
  int          act_n = 0;
  int          last_ack_cyc = 0;
  logic [51:0] exp_addr [0:15];
  int          exp_n;
  logic [51:0] next_tbl;

  function automatic logic [63:0] rd(input logic [51:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return 64'd0;
  endfunction

  task automatic put(input logic [51:0] a, input logic [63:0] v);
    mem_m[a] = v;
    if (wn < 16) begin wlist[wn] = a; wn++; end
  endtask

  function automatic logic [63:0] mk_ent(input bit p, input bit r, input bit w,
                                         input logic [2:0] nl, input logic [51:0] a);
    logic [63:0] e;
    e = 64'd0;
    e[0] = p; e[11:9] = nl; e[51:12] = a[51:12]; e[61] = r; e[62] = w;
    return e;
  endfunction

  function automatic logic [51:0] ent_addr(input logic [51:0] tbl, input logic [63:0] va,
                                           input int lvl);
    logic [63:0] ix;
    ix = (va >> (12 + 9 * (lvl - 1))) & 64'h1ff;
    return tbl + 52'(ix * 64'd8);
  endfunction

  function automatic logic [51:0] dte_addr(input logic [15:0] rid);
    return DT_BASE + 52'(rid) * 52'd32;
  endfunction

  task automatic clear_mem();
    mem_m.delete();
    wn = 0;
    err_en = 0;
    next_tbl = 52'h000_0020_0000;
  endtask

  // memory responder: 0..2 wait cycles, ack for one edge
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_ack = 1'b1;
          mem_rdata = rd(mem_addr);
          mem_err = err_en && (mem_addr == err_addr);
          if (act_n < 16) act_addr[act_n] = mem_addr;
          act_n++;
          last_ack_cyc = cyc + 1;
          wait_cnt = $urandom_range(0, 2);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic model(input logic [15:0] rid, input logic [63:0] va, input bit wr,
                       output logic [2:0] code, output logic [51:0] pa,
                       output logic [2:0] lvl, output logic [15:0] dom);
    logic [63:0] w0, w1, e, m;
    logic [51:0] a, tbl;
    bit r_ok, w_ok;
    int cur, nl, sh;
    code = 0; pa = 0; lvl = 0; dom = 0; exp_n = 0;
    a = dte_addr(rid);
    exp_addr[exp_n] = a; exp_n++;
    if (err_en && a == err_addr) begin code = 6; return; end
    w0 = rd(a);
    a = a + 52'd8;
    exp_addr[exp_n] = a; exp_n++;
    if (err_en && a == err_addr) begin code = 6; return; end
    w1 = rd(a);
    dom = w1[15:0];
    if (!w0[0]) begin code = 1; return; end
    cur = int'(w0[11:9]);
    if (cur == 0 || cur > 4) begin code = 5; return; end
    if ((va >> (12 + 9 * cur)) != 64'd0) begin code = 4; return; end
    r_ok = w0[61]; w_ok = w0[62];
    if (wr ? !w_ok : !r_ok) begin code = 3; return; end
    tbl = {w0[51:12], 12'h000};
    while (1) begin
      a = ent_addr(tbl, va, cur);
      exp_addr[exp_n] = a; exp_n++;
      if (err_en && a == err_addr) begin code = 6; return; end
      e = rd(a);
      if (!e[0]) begin code = 2; return; end
      r_ok = r_ok & e[61]; w_ok = w_ok & e[62];
      if (wr ? !w_ok : !r_ok) begin code = 3; return; end
      nl = int'(e[11:9]);
      if (nl == 0) begin
        sh = 12 + 9 * (cur - 1);
        m = (64'd1 << sh) - 64'd1;
        pa = 52'(({12'h000, e[51:12], 12'h000} & ~m) | (va & m));
        lvl = 3'(cur);
        return;
      end
      if (nl >= cur) begin code = 5; return; end
      if (((va >> (12 + 9 * nl)) & ((64'd1 << (9 * (cur - 1 - nl))) - 64'd1)) != 64'd0) begin
        code = 4; return;
      end
      tbl = {e[51:12], 12'h000};
      cur = nl;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] rid, input logic [63:0] va, input bit wr,
                       output logic [2:0] got_code, output logic [51:0] got_pa);
    logic [2:0] e_code, e_lvl;
    logic [51:0] e_pa;
    logic [15:0] e_dom;
    int t;
    model(rid, va, wr, e_code, e_pa, e_lvl, e_dom);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    act_n = 0;
    req_valid = 1'b1; req_rid = rid; req_va = va[VA_W-1:0]; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", 64'(req_ready), 64'd0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    got_code = rsp_fault; got_pa = rsp_pa;
    chk(rsp_fault == e_code, "R3/R4/R6/R7/R8/R10/R12 fault code", 64'(rsp_fault), 64'(e_code));
    chk(rsp_pa == e_pa, "R9/R11 physical address", 64'(rsp_pa), 64'(e_pa));
    chk(rsp_lvl == e_lvl, "R9 leaf level", 64'(rsp_lvl), 64'(e_lvl));
    chk(rsp_domain == e_dom, "R13 domain", 64'(rsp_domain), 64'(e_dom));
    chk(act_n == exp_n, "R2/R5 read count", 64'(act_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++)
      chk(act_addr[i] == exp_addr[i], "R2/R5 read address", 64'(act_addr[i]), 64'(exp_addr[i]));
    chk(cyc == last_ack_cyc, "R11 response one cycle after last ack", 64'(cyc), 64'(last_ack_cyc));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single-cycle pulse", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after response", 64'(req_ready), 64'd1);
  endtask

  task automatic build_random(output logic [15:0] rid, output logic [63:0] va, output bit wr);
    logic [63:0] w0, e;
    logic [51:0] tbl, ntbl, pg;
    int sl, cur, nl, pick, lo, hi;
    clear_mem();
    rid = 16'($urandom);
    va = {$urandom, $urandom} & 64'h0000_FFFF_FFFF_FFFF;
    wr = $urandom_range(0, 1);
    pick = $urandom_range(0, 99);
    sl = (pick < 3) ? 0 : (pick < 5) ? $urandom_range(5, 7) : $urandom_range(1, 4);
    if (sl >= 1 && sl <= 4 && $urandom_range(0, 9) != 0)
      va = va & ((64'd1 << (12 + 9 * sl)) - 64'd1);
    tbl = next_tbl; next_tbl = next_tbl + 52'h1000;
    w0 = mk_ent($urandom_range(0, 99) < 97, $urandom_range(0, 99) < 92,
                $urandom_range(0, 99) < 85, 3'(sl), tbl);
    put(dte_addr(rid), w0);
    put(dte_addr(rid) + 52'd8, {48'($urandom), 16'($urandom)});
    cur = sl;
    while (cur >= 1 && cur <= 4) begin
      if (cur == 1) nl = 0;
      else if ($urandom_range(0, 9) < 3) nl = 0;
      else nl = $urandom_range(1, cur - 1);
      if (cur > 1 && $urandom_range(0, 99) < 3) nl = cur;
      if (nl != 0 && nl < cur - 1 && $urandom_range(0, 7) != 0) begin
        lo = 12 + 9 * nl; hi = 12 + 9 * (cur - 1);
        va = va & ~(((64'd1 << hi) - 64'd1) & ~((64'd1 << lo) - 64'd1));
      end
      pg = {40'($urandom) ^ (40'($urandom) << 20), 12'h000};
      ntbl = next_tbl; next_tbl = next_tbl + 52'h1000;
      e = mk_ent($urandom_range(0, 99) < 96, $urandom_range(0, 99) < 95,
                 $urandom_range(0, 99) < 92, 3'(nl), (nl == 0) ? pg : ntbl);
      put(ent_addr(tbl, va, cur), e);
      if (nl == 0 || nl >= cur) break;
      tbl = ntbl; cur = nl;
    end
    if ($urandom_range(0, 99) < 6 && wn > 0) begin
      err_en = 1;
      err_addr = wlist[$urandom_range(0, wn - 1)];
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rid;
    logic [63:0] va;
    bit wr;
    logic [2:0] gc;
    logic [51:0] gp;
    logic [51:0] t4, t3, t2, t1;
    void'($urandom(32'h1F2E3D4C));

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(mem_req == 1'b0, "R2 no read in reset", 64'(mem_req), 64'd0);
    chk(rsp_valid == 1'b0, "R11 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;

    // full four-level walk to a 4 KB page
    clear_mem();
    rid = 16'h0012; va = 64'h0000_1234_5678_9ABC;
    va = va & 64'h0000_FFFF_FFFF_FFFF;
    t4 = 52'h30000; t3 = 52'h31000; t2 = 52'h32000; t1 = 52'h33000;
    put(dte_addr(rid), mk_ent(1, 1, 1, 3'd4, t4));
    put(dte_addr(rid) + 8, 64'h0000_0000_0000_BEEF);
    put(ent_addr(t4, va, 4), mk_ent(1, 1, 1, 3'd3, t3));
    put(ent_addr(t3, va, 3), mk_ent(1, 1, 1, 3'd2, t2));
    put(ent_addr(t2, va, 2), mk_ent(1, 1, 1, 3'd1, t1));
    put(ent_addr(t1, va, 1), mk_ent(1, 1, 1, 3'd0, 52'hA_BCDE_F000));
    apply(rid, va, 1'b0, gc, gp);
    chk(gp == 52'hA_BCDE_FABC, "R9 4KB page address", 64'(gp), 64'hA_BCDE_FABC);
    // write denied at level 2 only for writes (R7)
    put(ent_addr(t2, va, 2), mk_ent(1, 1, 0, 3'd1, t1));
    apply(rid, va, 1'b1, gc, gp);
    chk(gc == 3'd3, "R7 write denied at level 2", 64'(gc), 64'd3);
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd0, "R7 read still allowed", 64'(gc), 64'd0);
    // not present at level 3 (R6)
    put(ent_addr(t3, va, 3), mk_ent(0, 1, 1, 3'd2, t2));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd2, "R6 not present", 64'(gc), 64'd2);
    // not present outranks permission (R12)
    put(ent_addr(t3, va, 3), mk_ent(0, 0, 0, 3'd2, t2));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd2, "R12 present checked before rights", 64'(gc), 64'd2);
    // next level not below current (R8)
    put(ent_addr(t3, va, 3), mk_ent(1, 1, 1, 3'd3, t2));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd5, "R8 level order fault", 64'(gc), 64'd5);
    // error on the final read (R10)
    put(ent_addr(t3, va, 3), mk_ent(1, 1, 1, 3'd2, t2));
    err_en = 1; err_addr = ent_addr(t1, va, 1);
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd6, "R10 error on leaf read", 64'(gc), 64'd6);
    // error on first context read (R10, R13)
    err_addr = dte_addr(rid);
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd6 && rsp_domain == 16'd0, "R10/R13 error on context read",
        64'(gc), 64'd6);
    err_en = 0;
    // invalid context entry (R3)
    put(dte_addr(rid), mk_ent(0, 1, 1, 3'd4, t4));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd1, "R3 invalid context entry", 64'(gc), 64'd1);
    // start level 0 (R4)
    put(dte_addr(rid), mk_ent(1, 1, 1, 3'd0, t4));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd5, "R4 start level zero", 64'(gc), 64'd5);
    // start level 3 with va bits above 39 set (R4)
    put(dte_addr(rid), mk_ent(1, 1, 1, 3'd3, t3));
    apply(rid, va, 1'b0, gc, gp);
    chk(gc == 3'd4, "R4 upper address bits set", 64'(gc), 64'd4);

    // skip level 3: level 4 points at level 2, 2 MB leaf (R8, R9)
    clear_mem();
    rid = 16'h0345; va = 64'h0000_0080_0061_2345;
    t4 = 52'h40000; t2 = 52'h41000;
    put(dte_addr(rid), mk_ent(1, 1, 1, 3'd4, t4));
    put(dte_addr(rid) + 8, 64'h0000_0000_0000_0777);
    put(ent_addr(t4, va, 4), mk_ent(1, 1, 1, 3'd2, t2));
    put(ent_addr(t2, va, 2), mk_ent(1, 1, 1, 3'd0, 52'h4_5660_0000));
    apply(rid, va, 1'b1, gc, gp);
    chk(gp == 52'h4_5661_2345, "R9 2MB page after skip", 64'(gp), 64'h4_5661_2345);
    // skipped bits not zero (R8)
    va = va | 64'h0000_0000_4000_0000;
    put(ent_addr(t4, va, 4), mk_ent(1, 1, 1, 3'd2, t2));
    apply(rid, va, 1'b1, gc, gp);
    chk(gc == 3'd4, "R8 skipped bits nonzero", 64'(gc), 64'd4);

    // 1 GB leaf at level 3 with stray frame bits below page size (R9)
    clear_mem();
    rid = 16'h0001; va = 64'h0000_0000_7ABC_DEF1;
    t3 = 52'h50000;
    put(dte_addr(rid), mk_ent(1, 1, 1, 3'd3, t3));
    put(dte_addr(rid) + 8, 64'h0000_0000_0000_0042);
    put(ent_addr(t3, va, 3), mk_ent(1, 1, 1, 3'd0, 52'h3_C123_4000));
    apply(rid, va, 1'b0, gc, gp);
    chk(gp == 52'h3_FABC_DEF1, "R9 1GB page, frame low bits ignored", 64'(gp), 64'h3_FABC_DEF1);

    // random walks
    for (int n = 0; n < 400; n++) begin
      build_random(rid, va, wr);
      apply(rid, va, wr, gc, gp);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule